// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block takes the outcome of an address translation and decides whether the access may go ahead. The inputs are the translation result (the domain number, whether the mapping is a section or a small page, the permission fields and the cache attribute bits) and the access itself (read or write, user or supervisor, data or instruction fetch, and the virtual address bits that pick a 1 KB sub-page). The block looks up the domain's two-bit access mode in a 32-bit domain control word. When the mode is manager, the block allows the access. When the mode is client, it applies the permission code. Any other mode gives a domain fault.

There is one verdict per request: allow, domain fault or permission fault. The same registered result also carries a decoded memory-type code taken from the cache attribute bits. The result appears one clock after a request is presented. The table walker sits in front of the block and a fault recorder sits behind it. Neither is part of this block.

Top module: `acc_perm_check`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle in which `chk_valid` is high. After reset, `res_valid`, `allow`, `dom_fault`, `perm_fault` and `mem_type` are all 0.
- R2: The mode of domain d is `dacr[2d+1:2d]`. A mode of 0 (none) or 2 (reserved) gives a domain fault.
- R3: Mode 3 (manager) allows every access, whatever the permission code and the control bits.
- R4: Mode 1 (client) applies the selected permission code. Every valid result has exactly one of `allow`, `dom_fault` and `perm_fault` high.
- R5: Permission code 1 allows supervisor reads and writes. It denies every user access.
- R6: Permission code 2 allows any supervisor access and user reads, and denies user writes. Permission code 3 allows everything.
- R7: For permission code 0, the result depends on `sys_prot` and `rom_prot`. With `sys_prot`=1 and `rom_prot`=0, only supervisor reads are allowed. With `sys_prot`=0 and `rom_prot`=1, reads are allowed in both modes. Both other combinations deny all access.
- R8: For a small page (`map_small`=1), `desc_ap` holds descriptor bits 11:4. Sub-page i (i = `va_sub`, virtual address bits 11:10) uses descriptor bits 2i+5:2i+4, which are `desc_ap[2i+1:2i]`.
- R9: For a section (`map_small`=0), the permission code is descriptor bits 11:10 (`desc_ap[7:6]`), and `va_sub` has no effect.
- R10: For data accesses, `mem_type` is {0, C, B}. The codes are 0 uncached and unbuffered, 1 uncached but buffered, 2 write-through and 3 write-back.
- R11: An instruction fetch (`is_fetch`=1) is checked as a read, so `is_write` has no effect. Its `mem_type` is 5 when C=1 and 4 when C=0; B has no effect.
- R12: When the domain mode gives a fault, only `dom_fault` is raised, even if the permission code would also deny the access.
- R13: While `chk_valid` is low, `allow`, `dom_fault`, `perm_fault` and `mem_type` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Request present this cycle |
| is_write | input | 1 | 1 = write, 0 = read |
| is_user | input | 1 | 1 = user mode, 0 = supervisor |
| is_fetch | input | 1 | 1 = instruction fetch |
| dom_id | input | 4 | Domain number from the descriptor |
| dacr | input | 32 | Domain control word, 2 bits per domain |
| map_small | input | 1 | 1 = small page, 0 = section |
| va_sub | input | 2 | Virtual address bits 11:10 |
| desc_ap | input | 8 | Descriptor bits 11:4 (permission fields) |
| attr_c | input | 1 | Cacheable attribute bit |
| attr_b | input | 1 | Bufferable attribute bit |
| sys_prot | input | 1 | System protection control bit |
| rom_prot | input | 1 | ROM protection control bit |
| res_valid | output | 1 | Result valid |
| allow | output | 1 | Access allowed |
| dom_fault | output | 1 | Domain fault |
| perm_fault | output | 1 | Permission fault |
| mem_type | output | 3 | Decoded memory type |

## Verification
The bench sweeps every domain mode, every permission code, all four protection-bit pairs, every access kind, both mapping sizes, every sub-page and every attribute pair. The domain fields and permission fields that are not selected are filled with contrasting values. A checker that reads the wrong domain field or the wrong sub-page field therefore gives verdicts that disagree with the model. A section check that read a sub-page field would show up as `va_sub` changing the verdict. A reserved mode treated as client would show up as an allow or a permission fault where only a domain fault is expected. Letting `is_write` through on a fetch would turn allowed fetches into permission faults. Other faults the sweep exposes are a permission fault reported alongside a domain fault, and B leaking into the fetch memory type. A separate hold phase shows whether outputs change without a request.

// File: rtl/acc_perm_pkg.sv
package acc_perm_pkg;

    typedef enum logic [1:0] {
        DM_NONE    = 2'd0,
        DM_CLIENT  = 2'd1,
        DM_RSVD    = 2'd2,
        DM_MANAGER = 2'd3
    } dom_mode_e;

    typedef enum logic [2:0] {
        MT_STALL   = 3'd0,
        MT_BUFF    = 3'd1,
        MT_WTHRU   = 3'd2,
        MT_WBACK   = 3'd3,
        MT_I_UNC   = 3'd4,
        MT_I_CACHE = 3'd5
    } mem_type_e;

    typedef struct packed {
        logic allow;
        logic dom_fault;
        logic perm_fault;
    } verdict_t;

    // Does a permission code grant this access?
    function automatic logic ap_grants(input logic [1:0] ap,
                                       input logic       sys_b,
                                       input logic       rom_b,
                                       input logic       user,
                                       input logic       write);
        logic g;
        case (ap)
            2'd0: begin
                if (sys_b && !rom_b)      g = !user && !write;
                else if (!sys_b && rom_b) g = !write;
                else                      g = 1'b0;
            end
            2'd1:    g = !user;
            2'd2:    g = !user || !write;
            default: g = 1'b1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/dom_lookup.sv
module dom_lookup
    import acc_perm_pkg::*;
#(
    parameter int DOM_CNT = 16,
    localparam int DOM_W  = $clog2(DOM_CNT),
    localparam int CTRL_W = 2 * DOM_CNT
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [DOM_W-1:0]  dom_sel,
    output dom_mode_e         mode
);

    logic [1:0] fields [DOM_CNT];

    for (genvar g = 0; g < DOM_CNT; g++) begin : g_field
        assign fields[g] = ctrl_word[2*g+1 : 2*g];
    end

    assign mode = dom_mode_e'(fields[dom_sel]);

endmodule

// File: rtl/perm_select.sv
module perm_select #(
    parameter int SUBPAGES = 4,
    localparam int SUB_W   = $clog2(SUBPAGES),
    localparam int FLD_W   = 2 * SUBPAGES
) (
    input  logic [FLD_W-1:0] ap_fields,
    input  logic             small_pg,
    input  logic [SUB_W-1:0] sub_idx,
    output logic [1:0]       ap_code
);

    logic [1:0] fld [SUBPAGES];

    for (genvar g = 0; g < SUBPAGES; g++) begin : g_sub
        assign fld[g] = ap_fields[2*g+1 : 2*g];
    end

    // A section uses the highest field only.
    assign ap_code = small_pg ? fld[sub_idx] : fld[SUBPAGES-1];

endmodule

// File: rtl/attr_decode.sv
module attr_decode
    import acc_perm_pkg::*;
(
    input  logic      c_bit,
    input  logic      b_bit,
    input  logic      fetch,
    output mem_type_e mtype
);

    always_comb begin
        if (fetch)
            mtype = c_bit ? MT_I_CACHE : MT_I_UNC;
        else
            mtype = mem_type_e'({1'b0, c_bit, b_bit});
    end

endmodule

// File: rtl/acc_perm_check.sv
module acc_perm_check
    import acc_perm_pkg::*;
#(
    parameter int DOM_CNT  = 16,
    parameter int SUBPAGES = 4,
    localparam int DOM_W   = $clog2(DOM_CNT),
    localparam int CTRL_W  = 2 * DOM_CNT,
    localparam int SUB_W   = $clog2(SUBPAGES),
    localparam int FLD_W   = 2 * SUBPAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic              is_write,
    input  logic              is_user,
    input  logic              is_fetch,
    input  logic [DOM_W-1:0]  dom_id,
    input  logic [CTRL_W-1:0] dacr,
    input  logic              map_small,
    input  logic [SUB_W-1:0]  va_sub,
    input  logic [FLD_W-1:0]  desc_ap,
    input  logic              attr_c,
    input  logic              attr_b,
    input  logic              sys_prot,
    input  logic              rom_prot,
    output logic              res_valid,
    output logic              allow,
    output logic              dom_fault,
    output logic              perm_fault,
    output logic [2:0]        mem_type
);

    dom_mode_e mode;
    logic [1:0] ap_code;
    mem_type_e  mtype;
    logic       granted;
    logic       eff_write;
    verdict_t   vd;

    dom_lookup #(.DOM_CNT(DOM_CNT)) dom_i (
        .ctrl_word (dacr),
        .dom_sel   (dom_id),
        .mode      (mode)
    );

    perm_select #(.SUBPAGES(SUBPAGES)) sel_i (
        .ap_fields (desc_ap),
        .small_pg  (map_small),
        .sub_idx   (va_sub),
        .ap_code   (ap_code)
    );

    attr_decode attr_i (
        .c_bit (attr_c),
        .b_bit (attr_b),
        .fetch (is_fetch),
        .mtype (mtype)
    );

    // A fetch is always checked as a read.
    assign eff_write = is_write && !is_fetch;
    assign granted   = ap_grants(ap_code, sys_prot, rom_prot, is_user, eff_write);

    always_comb begin
        vd = '0;
        case (mode)
            DM_MANAGER: vd.allow = 1'b1;
            DM_CLIENT: begin
                vd.allow      = granted;
                vd.perm_fault = !granted;
            end
            default:    vd.dom_fault = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            allow      <= 1'b0;
            dom_fault  <= 1'b0;
            perm_fault <= 1'b0;
            mem_type   <= '0;
        end else begin
            res_valid <= chk_valid;
            if (chk_valid) begin
                allow      <= vd.allow;
                dom_fault  <= vd.dom_fault;
                perm_fault <= vd.perm_fault;
                mem_type   <= mtype;
            end
        end
    end

endmodule

// File: rtl/acc_perm_check_sva.sv
module acc_perm_check_sva #(
    parameter int DOM_CNT  = 16,
    parameter int SUBPAGES = 4,
    localparam int DOM_W   = $clog2(DOM_CNT),
    localparam int CTRL_W  = 2 * DOM_CNT,
    localparam int SUB_W   = $clog2(SUBPAGES),
    localparam int FLD_W   = 2 * SUBPAGES
) (
    input logic              clk,
    input logic              rst,
    input logic              chk_valid,
    input logic              is_fetch,
    input logic [DOM_W-1:0]  dom_id,
    input logic [CTRL_W-1:0] dacr,
    input logic              attr_c,
    input logic              attr_b,
    input logic              res_valid,
    input logic              allow,
    input logic              dom_fault,
    input logic              perm_fault,
    input logic [2:0]        mem_type
);

    logic [1:0] dfld [DOM_CNT];
    for (genvar g = 0; g < DOM_CNT; g++) begin : g_f
        assign dfld[g] = dacr[2*g+1 : 2*g];
    end
    logic [1:0] cur_mode;
    assign cur_mode = dfld[dom_id];

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> res_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !res_valid);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !allow && !dom_fault && !perm_fault));
    // R4
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({allow, dom_fault, perm_fault}) == 1));
    // R2
    dom_none_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !cur_mode[0]) |=> dom_fault);
    // R3
    manager_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && cur_mode == 2'd3) |=> allow);
    // R12
    dom_prio_chk: assert property (@(posedge clk) disable iff (rst)
        dom_fault |-> !perm_fault);
    // R10
    data_type_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !is_fetch) |=> mem_type == {1'b0, $past(attr_c), $past(attr_b)});
    // R13
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> ($stable(allow) && $stable(dom_fault) &&
                        $stable(perm_fault) && $stable(mem_type)));

endmodule

bind acc_perm_check acc_perm_check_sva #(.DOM_CNT(DOM_CNT), .SUBPAGES(SUBPAGES)) sva_i (
    .clk        (clk),
    .rst        (rst),
    .chk_valid  (chk_valid),
    .is_fetch   (is_fetch),
    .dom_id     (dom_id),
    .dacr       (dacr),
    .attr_c     (attr_c),
    .attr_b     (attr_b),
    .res_valid  (res_valid),
    .allow      (allow),
    .dom_fault  (dom_fault),
    .perm_fault (perm_fault),
    .mem_type   (mem_type)
);

// File: tb/acc_perm_check_tb_top.sv
`timescale 1ns/1ps
module acc_perm_check_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        chk_valid, is_write, is_user, is_fetch;
    logic [3:0]  dom_id;
    logic [31:0] dacr;
    logic        map_small;
    logic [1:0]  va_sub;
    logic [7:0]  desc_ap;
    logic        attr_c, attr_b, sys_prot, rom_prot;
    logic        res_valid, allow, dom_fault, perm_fault;
    logic [2:0]  mem_type;

    int applied = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    acc_perm_check dut_i (
        .clk(clk), .rst(rst), .chk_valid(chk_valid), .is_write(is_write),
        .is_user(is_user), .is_fetch(is_fetch), .dom_id(dom_id), .dacr(dacr),
        .map_small(map_small), .va_sub(va_sub), .desc_ap(desc_ap),
        .attr_c(attr_c), .attr_b(attr_b), .sys_prot(sys_prot), .rom_prot(rom_prot),
        .res_valid(res_valid), .allow(allow), .dom_fault(dom_fault),
        .perm_fault(perm_fault), .mem_type(mem_type)
    );

    function automatic bit model_grant(int ap, bit s, bit r, bit u, bit w);
        case (ap)
            0: begin
                if (s && !r) return !u && !w;   // R7
                if (!s && r) return !w;         // R7
                return 1'b0;
            end
            1: return !u;                       // R5
            2: return !u || !w;                 // R6
            default: return 1'b1;               // R6
        endcase
    endfunction

    task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
        applied++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got {valid,allow,dfault,pfault,type}=%b_%b_%b_%b_%03b exp %b_%b_%b_%b_%03b",
                     tag, got[5], got[4], got[3], 1'b0, 3'b0, exp[5], exp[4], exp[3], 1'b0, 3'b0);
        end
    endtask

    task automatic check_all(string tag, logic v, logic a, logic df, logic pf, logic [2:0] mt);
        applied++;
        if ({res_valid, allow, dom_fault, perm_fault, mem_type} !== {v, a, df, pf, mt}) begin
            fails++;
            $display("FAIL %s: got %b %b %b %b %0d exp %b %b %b %b %0d", tag,
                     res_valid, allow, dom_fault, perm_fault, mem_type, v, a, df, pf, mt);
        end
    endtask

    initial begin
        #(4 * 60000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run exp finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        int idx;
        rst = 1'b1; chk_valid = 0; is_write = 0; is_user = 0; is_fetch = 0;
        dom_id = 0; dacr = 0; map_small = 0; va_sub = 0; desc_ap = 0;
        attr_c = 0; attr_b = 0; sys_prot = 0; rom_prot = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
        rst = 1'b0;
        idx = 0;
        for (int dv = 0; dv < 4; dv++)
        for (int ap = 0; ap < 4; ap++)
        for (int sr = 0; sr < 4; sr++)
        for (int k = 0; k < 8; k++)
        for (int sm = 0; sm < 2; sm++)
        for (int sb = 0; sb < 4; sb++)
        for (int cb = 0; cb < 4; cb++) begin
            int d, fillv, sel, eap;
            bit w, u, f, ew, g, e_a, e_df, e_pf;
            logic [2:0] e_mt;
            string tag;
            d = idx % 16;
            fillv = dv ^ 1;
            for (int j = 0; j < 16; j++) dacr[2*j +: 2] = 2'(fillv);
            dacr[2*d +: 2] = 2'(dv);
            sel = sm ? sb : 3;                  // R8, R9
            for (int j = 0; j < 4; j++) desc_ap[2*j +: 2] = 2'(ap ^ 3);
            desc_ap[2*sel +: 2] = 2'(ap);
            w = k[0]; u = k[1]; f = k[2];
            chk_valid = 1'b1; is_write = w; is_user = u; is_fetch = f;
            dom_id = 4'(d); map_small = sm[0]; va_sub = 2'(sb);
            attr_c = cb[1]; attr_b = cb[0];
            sys_prot = sr[1]; rom_prot = sr[0];
            // expected, from the requirements
            eap = ap;
            ew = w && !f;                       // R11
            g = model_grant(eap, sr[1], sr[0], u, ew);
            e_a = 0; e_df = 0; e_pf = 0;
            if (dv == 0 || dv == 2) begin e_df = 1; tag = "R2/R12"; end
            else if (dv == 3) begin e_a = 1; tag = "R3"; end
            else begin
                e_a = g; e_pf = !g;
                tag = (ap == 0) ? "R7" : (ap == 1) ? "R5" : "R6";
                tag = {tag, sm ? " R8" : " R9", " R4"};
            end
            if (f) e_mt = cb[1] ? 3'd5 : 3'd4;  // R11
            else   e_mt = 3'(cb);               // R10
            tag = {tag, f ? " R11" : " R10"};
            @(negedge clk);
            check_all(tag, 1'b1, e_a, e_df, e_pf, e_mt);
            idx++;
        end
        // R13: outputs hold with no request; R1: valid drops
        begin
            logic a0, d0, p0;
            logic [2:0] m0;
            a0 = allow; d0 = dom_fault; p0 = perm_fault; m0 = mem_type;
            chk_valid = 1'b0; dacr = 32'h0; dom_id = 4'd5; attr_c = ~attr_c;
            is_fetch = 1'b0; attr_b = ~attr_b; desc_ap = 8'h00; is_user = 1'b1;
            @(negedge clk);
            check_all("R13 hold/R1 idle", 1'b0, a0, d0, p0, m0);
            @(negedge clk);
            check_all("R13 hold second cycle", 1'b0, a0, d0, p0, m0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

endmodule